// File: doc/BRIEF.md
# Weighted Receive/Transmit Bus Arbiter

This block decides which of two DMA engines may use a shared host-bus master port. One engine receives and the other transmits. Each engine raises its request line and keeps it high for a whole transaction. The arbiter answers with one registered grant and holds that grant until the granted engine pulses its done line. The arbiter leaves an idle cycle after each done pulse and arbitrates again in that cycle.

Two policies are available through a mode input. Fixed priority always favours the receive engine. Weighted round-robin uses a 2-bit ratio code, which lets the receive engine take several consecutive transactions before the transmit engine gets one turn. A saturating credit counter counts the receive grants given since the last transmit grant. The mode and ratio inputs are plain ports. They only affect a decision made while no grant is active.

Top module: `rxtx_weighted_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both grants go low and the credit count clears to zero. After reset, with weighted mode and both sides requesting, the first grant goes to receive.
- R2: At most one grant is high at any time. A grant rises in the cycle after a request is seen while no grant is active.
- R3: A grant stays high until the granted side pulses its own done line. A done pulse from the other side, or a done pulse while idle, has no effect.
- R4: In the cycle after the granted side's done pulse, both grants are low. Arbitration takes place in that idle cycle, and the next grant can appear in the cycle after it.
- R5: With `fixed_prio` = 1, receive is granted whenever both sides request, whatever the credit count.
- R6: With `fixed_prio` = 0 and both sides requesting, receive is granted until it has won N grants since the last transmit grant. Transmit then wins once. N is 1, 2, 3 or 4 for `ratio` codes 00, 01, 10 and 11.
- R7: When only one side requests in an idle cycle, that side is granted, whatever the mode and the credit count.
- R8: Each receive grant adds one to the credit count, which saturates at 4. Each transmit grant clears the count to zero. This happens in both modes.
- R9: A change of `fixed_prio` or `ratio` while a grant is active does not change that grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fixed_prio | input | 1 | 1 = receive always wins; 0 = weighted round-robin |
| ratio | input | 2 | Receive-to-transmit weight code; N = code + 1 |
| rx_req | input | 1 | Receive engine requests the bus |
| tx_req | input | 1 | Transmit engine requests the bus |
| rx_done | input | 1 | Receive engine ends its transaction (one-cycle pulse) |
| tx_done | input | 1 | Transmit engine ends its transaction (one-cycle pulse) |
| rx_gnt | output | 1 | Bus granted to the receive engine |
| tx_gnt | output | 1 | Bus granted to the transmit engine |

## Verification
The assertions check the following on every cycle:
- The grants are one-hot.
- A grant is held until its own done pulse and released the cycle after it.
- A lone requester is served.
- Fixed-priority mode favours receive.
- The transmit turn falls due once the credit reaches the ratio limit.
- The credit counter saturates and clears as R8 specifies.

Some behaviour only the bench's scenarios can show. One is the full weighted sequence of N receive grants and then one transmit grant for every ratio code, observed at the ports. Another is that configuration changes during a grant have no effect. A third is the exact cycle of each new grant across long random mixes of requests, done pulses and mode changes. The bench checks these against its own model of the requirements.

// File: rtl/rxtx_arb_pkg.sv
// Shared types and constants for the weighted receive/transmit arbiter.
// Assumes the ratio code is a small unsigned number; limit = code + 1.
package rxtx_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_RX   = 2'd1,
        ARB_TX   = 2'd2
    } arb_state_e;

    // Number of receive grants before a transmit turn, for a given code.
    function automatic int unsigned ratio_limit(input int unsigned code);
        return code + 1;
    endfunction

endpackage

// File: rtl/rxtx_credit_ctr.sv
// Saturating credit counter: counts receive grants since the last
// transmit grant. Assumes inc and clr are never high together.
module rxtx_credit_ctr #(
    parameter int MAX_COUNT = 4,
    localparam int CNT_W    = $clog2(MAX_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_COUNT);

    // Update the credit: clear on a transmit grant, step up on a receive grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != MAX_V) begin
            count <= count + 1'b1;
        end
    end

    // R8: the count never passes its ceiling
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        count <= MAX_V);

    // R8: a transmit grant empties the credit
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    // R8: a receive grant below the ceiling adds exactly one
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count < MAX_V) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/rxtx_pick.sv
// Combinational decision: picks which requester wins if the arbiter is
// idle this cycle. Assumes the credit is the count of receive grants
// since the last transmit grant.
module rxtx_pick #(
    parameter int RATIO_W = 2,
    parameter int CNT_W   = 3
) (
    input  logic               rx_req,
    input  logic               tx_req,
    input  logic               fixed_prio,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [CNT_W-1:0]   credit,
    output logic               pick_rx,
    output logic               pick_tx
);

    logic [CNT_W-1:0] limit;
    logic             tx_turn;

    // Derive the transmit turn from the credit and the programmed weight.
    always_comb begin
        limit   = CNT_W'(ratio) + CNT_W'(1);
        tx_turn = !fixed_prio && (credit >= limit);
    end

    // Choose the winner; a lone requester always wins.
    always_comb begin
        pick_rx = rx_req && !(tx_req && tx_turn);
        pick_tx = tx_req && (!rx_req || tx_turn);
    end

endmodule

// File: rtl/rxtx_grant_fsm.sv
// Grant state machine: latches the picked side and holds its grant until
// that side pulses done; inserts one idle cycle after each done pulse.
// Assumes pick_rx and pick_tx are never high together.
module rxtx_grant_fsm
    import rxtx_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pick_rx,
    input  logic pick_tx,
    input  logic rx_done,
    input  logic tx_done,
    output logic rx_gnt,
    output logic tx_gnt,
    output logic idle,
    output logic launch_rx,
    output logic launch_tx
);

    arb_state_e state;

    // Advance the grant state on picks and on the owner's done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            unique case (state)
                ARB_IDLE: begin
                    if (pick_rx)      state <= ARB_RX;
                    else if (pick_tx) state <= ARB_TX;
                end
                ARB_RX:  if (rx_done) state <= ARB_IDLE;
                ARB_TX:  if (tx_done) state <= ARB_IDLE;
                default: state <= ARB_IDLE;
            endcase
        end
    end

    // Decode the grant outputs and the grant-launch strobes.
    always_comb begin
        idle      = (state == ARB_IDLE);
        rx_gnt    = (state == ARB_RX);
        tx_gnt    = (state == ARB_TX);
        launch_rx = idle && pick_rx;
        launch_tx = idle && pick_tx && !pick_rx;
    end

    // R2: never two grants at once
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_gnt, tx_gnt}));

    // R3: receive grant held until its own done
    a_r3_hold_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt && !rx_done) |=> rx_gnt);

    // R3: transmit grant held until its own done
    a_r3_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && !tx_done) |=> tx_gnt);

    // R4: an idle cycle follows every done pulse
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_gnt && rx_done) || (tx_gnt && tx_done)) |=> (!rx_gnt && !tx_gnt));

endmodule

// File: rtl/rxtx_weighted_arbiter.sv
// Top level: two-way bus arbiter between a receive and a transmit DMA
// engine, with fixed priority or weighted round-robin. Assumes each
// requester holds its request for a whole transaction and pulses done once.
module rxtx_weighted_arbiter #(
    parameter int RATIO_W   = 2,
    localparam int MAX_CRED = 2 ** RATIO_W,
    localparam int CNT_W    = $clog2(MAX_CRED + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fixed_prio,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               rx_req,
    input  logic               tx_req,
    input  logic               rx_done,
    input  logic               tx_done,
    output logic               rx_gnt,
    output logic               tx_gnt
);

    logic [CNT_W-1:0] credit;
    logic             pick_rx;
    logic             pick_tx;
    logic             idle;
    logic             launch_rx;
    logic             launch_tx;

    rxtx_pick #(
        .RATIO_W (RATIO_W),
        .CNT_W   (CNT_W)
    ) u_pick (
        .rx_req     (rx_req),
        .tx_req     (tx_req),
        .fixed_prio (fixed_prio),
        .ratio      (ratio),
        .credit     (credit),
        .pick_rx    (pick_rx),
        .pick_tx    (pick_tx)
    );

    rxtx_grant_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_rx   (pick_rx),
        .pick_tx   (pick_tx),
        .rx_done   (rx_done),
        .tx_done   (tx_done),
        .rx_gnt    (rx_gnt),
        .tx_gnt    (tx_gnt),
        .idle      (idle),
        .launch_rx (launch_rx),
        .launch_tx (launch_tx)
    );

    rxtx_credit_ctr #(
        .MAX_COUNT (MAX_CRED)
    ) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (launch_rx),
        .clr   (launch_tx),
        .count (credit)
    );

    // R5: fixed priority serves receive whenever it asks while idle
    a_r5_fixed_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && fixed_prio && rx_req) |=> rx_gnt);

    // R7: a lone requester is served in the next cycle
    a_r7_lone_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_req && !tx_req) |=> rx_gnt);

    a_r7_lone_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tx_req && !rx_req) |=> tx_gnt);

    // R6: once the credit reaches the weight, transmit gets its turn
    a_r6_tx_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !fixed_prio && rx_req && tx_req &&
         credit >= CNT_W'(ratio) + CNT_W'(1)) |=> tx_gnt);

    // R6: below the weight, receive keeps winning
    a_r6_rx_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !fixed_prio && rx_req && tx_req &&
         credit < CNT_W'(ratio) + CNT_W'(1)) |=> rx_gnt);

endmodule

// File: tb/test_rxtx_weighted_arbiter.sv
module test_rxtx_weighted_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fixed_prio = 1'b0;
    logic [1:0] ratio = 2'b00;
    logic       rx_req = 1'b0;
    logic       tx_req = 1'b0;
    logic       rx_done = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_gnt;
    logic       tx_gnt;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state, built from the requirements
    bit m_rx = 0;
    bit m_tx = 0;
    int m_cred = 0;

    always #2 clk = ~clk;   // 250 MHz

    rxtx_weighted_arbiter i_rxtx_weighted_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_prio (fixed_prio),
        .ratio      (ratio),
        .rx_req     (rx_req),
        .tx_req     (tx_req),
        .rx_done    (rx_done),
        .tx_done    (tx_done),
        .rx_gnt     (rx_gnt),
        .tx_gnt     (tx_gnt)
    );

    function automatic bit want_tx(input bit fx, input int cred, input int code);
        return !fx && (cred >= code + 1);
    endfunction

    task automatic check(input string tag);
        checks++;
        if (rx_gnt !== m_rx || tx_gnt !== m_tx) begin
            errors++;
            $display("FAIL %s: grants rx/tx actual=%b%b expected=%b%b",
                     tag, rx_gnt, tx_gnt, m_rx, m_tx);
        end
    endtask

    // Drive one cycle of inputs at the negedge, advance the model, check at next negedge.
    task automatic step(input bit rr, input bit tr, input bit rd, input bit td,
                        input bit fx, input logic [1:0] rt, input string tag);
        rx_req = rr; tx_req = tr; rx_done = rd; tx_done = td;
        fixed_prio = fx; ratio = rt;
        if (m_rx) begin
            if (rd) m_rx = 0;
        end else if (m_tx) begin
            if (td) m_tx = 0;
        end else if (rr && !(tr && want_tx(fx, m_cred, int'(rt)))) begin
            m_rx = 1;
            if (m_cred < 4) m_cred++;
        end else if (tr) begin
            m_tx = 1;
            m_cred = 0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    // Both sides keep requesting; the owner ends its transaction immediately.
    task automatic busy_run(input int cycles, input bit fx, input logic [1:0] rt, input string tag);
        for (int i = 0; i < cycles; i++)
            step(1, 1, m_rx, m_tx, fx, rt, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        checks++;
        if (rx_gnt !== 1'b0 || tx_gnt !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset grants actual=%b%b expected=00", rx_gnt, tx_gnt);
        end
        rst_n = 1'b1;
        check("R1 idle after reset");

        // R1: first contested grant goes to receive (credit zero)
        step(1, 1, 0, 0, 0, 2'b00, "R1 first contested grant");
        checks++;
        if (rx_gnt !== 1'b1) begin
            errors++;
            $display("FAIL R1: first grant rx actual=%b expected=1", rx_gnt);
        end

        // R3: other side's done and repeated cycles do not drop the grant
        step(1, 1, 0, 1, 0, 2'b00, "R3 foreign done ignored");
        step(1, 1, 0, 0, 0, 2'b00, "R3 grant held");
        // R9: configuration change during grant has no effect
        step(1, 1, 0, 0, 1, 2'b11, "R9 config change during grant");
        step(1, 1, 0, 0, 0, 2'b10, "R9 config change during grant");
        // R4: done releases, idle cycle, then new grant (tx: credit 1 >= 1)
        step(1, 1, 1, 0, 0, 2'b00, "R4 done releases grant");
        checks++;
        if (rx_gnt !== 1'b0 || tx_gnt !== 1'b0) begin
            errors++;
            $display("FAIL R4: idle after done actual=%b%b expected=00", rx_gnt, tx_gnt);
        end
        step(1, 1, 0, 0, 0, 2'b00, "R4 regrant after idle");
        step(0, 0, 0, 1, 0, 2'b00, "R4 tx release");
        // R3: done while idle ignored
        step(0, 0, 1, 1, 0, 2'b00, "R3 done while idle");

        // R6: each ratio code under continuous contention
        for (int c = 0; c < 4; c++) begin
            busy_run(40, 0, 2'(c), "R6 weighted sequence");
        end
        // R5: fixed priority under contention, credit saturates (R8)
        busy_run(30, 1, 2'b00, "R5 fixed priority");
        busy_run(12, 0, 2'b11, "R8 saturated credit then transmit");
        // R7: lone requesters
        for (int i = 0; i < 6; i++) begin
            step(0, 1, m_rx, m_tx, 1, 2'b00, "R7 lone transmit");
            step(1, 0, m_rx, m_tx, 0, 2'b00, "R7 lone receive");
        end

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit rr = ($urandom_range(0, 3) != 0);
            bit tr = ($urandom_range(0, 3) != 0);
            bit rd = m_rx && ($urandom_range(0, 2) == 0);
            bit td = m_tx && ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 9) == 0) rd = 1;
            if ($urandom_range(0, 9) == 0) td = 1;
            step(rr, tr, rd, td, ($urandom_range(0, 4) == 0),
                 2'($urandom_range(0, 3)), "R2 R6 R8 random mix");
        end

        // R1: reset mid-grant clears everything, credit back to zero
        step(1, 1, 0, 0, 0, 2'b00, "R1 pre-reset");
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        m_rx = 0; m_tx = 0; m_cred = 0;
        check("R1 reset mid-run");
        rst_n = 1'b1;
        busy_run(8, 0, 2'b01, "R1 R6 after reset");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule